// File: doc/BRIEF.md
# Platform Power-Up Sequencer

This block is the power-control state machine of a notebook-class board. It brings the board from off to running after a press of an active-low power button. A filtered press starts a switch-on request to the south bridge. Once the south bridge drives both of its sleep-state lines high, the sequencer turns on the power rails in a fixed order, each a set delay after the one before: the suspend rail first, then the main rails, then the core regulator (active-low enable). It then waits for the regulator's power-good.

When power-good arrives, the block drives power-OK to the north bridge and the south bridge together. It then releases the downstream reset chain in its own model: CPU power-good, then PCI reset release, then CPU reset release after a hold window. If the regulator stays silent past a timeout, every enable drops and the block goes back to idle. It also goes back to idle if the sleep lines or power-good are lost while powered. All four inputs are asynchronous and are synchronised inside the block.

Top module: `pwr_seq_top`

## Requirements
- R1: During and directly after reset, every enable, power-OK, CPU power-good and both reset releases are inactive: swOnReqN=1, coreVrEnN=1, and all other outputs are 0.
- R2: buttonN must read low for DEB_CYC consecutive synchronised samples before it counts as a press. swOnReqN falls DEB_CYC+2 cycles after buttonN falls. Low pulses shorter than DEB_CYC cycles are ignored, and so are presses made while the block is not idle.
- R3: swOnReqN stays low until both sbSlpB and sbSlpC read high. swOnReqN rises and suspRailEn rises 3 cycles after the later of the two goes high.
- R4: mainRailEn rises STEP_CYC cycles after suspRailEn, and coreVrEnN falls STEP_CYC cycles after mainRailEn.
- R5: A vrmGood rise seen while the core regulator is enabled raises nbPwrOk and sbPwrOk together 3 cycles later.
- R6: If vrmGood has not risen by the cycle that is 3 cycles before the core regulator has been enabled for PG_TIMEOUT cycles, every output returns to its R1 value PG_TIMEOUT cycles after coreVrEnN fell. A fresh press is then needed.
- R7: cpuPwrGood rises STEP_CYC cycles after power-OK, and pciRstN rises STEP_CYC cycles after cpuPwrGood.
- R8: cpuRstN rises HOLD_CYC cycles after pciRstN. cpuPwrGood has then been high without a break for at least HOLD_CYC cycles (1 ms at 50 MHz by default).
- R9: After the sleep-line handshake, a low on either sleep line returns every output to its R1 value 3 cycles later. After power-OK, a loss of vrmGood does the same.
- R10: The outputs are always nested: main rail implies suspend rail, core enable implies main rail, power-OK implies core enable, CPU power-good implies power-OK, pciRstN high implies CPU power-good, and cpuRstN high implies pciRstN high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| buttonN | input | 1 | Power button, low when pressed |
| sbSlpB | input | 1 | South bridge sleep-state line B, high when awake |
| sbSlpC | input | 1 | South bridge sleep-state line C, high when awake |
| vrmGood | input | 1 | Core regulator power-good |
| swOnReqN | output | 1 | Switch-on request to the south bridge, active low |
| suspRailEn | output | 1 | Suspend rail enable |
| mainRailEn | output | 1 | Main rails enable |
| coreVrEnN | output | 1 | Core regulator enable, active low |
| nbPwrOk | output | 1 | Power-OK to the north bridge |
| sbPwrOk | output | 1 | Power-OK to the south bridge |
| cpuPwrGood | output | 1 | CPU power-good |
| pciRstN | output | 1 | PCI reset, active low |
| cpuRstN | output | 1 | CPU reset, active low |

## Verification
A sleep-line or power-good input change shows at the outputs after three clock edges: two synchroniser stages plus the registered output. A button edge takes DEB_CYC+2 edges. Each step between rails, power-OK and the reset releases takes exactly its delay parameter. The bench drives each input at a falling edge and counts falling-edge samples from there. It checks that the whole output vector keeps its old value on every sample before the due cycle and takes the new value on the due cycle. The pass/fail edge of the power-good timeout is tested from both sides, one cycle apart.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_SUSP, ST_MAIN, ST_CORE,
    ST_PWROK, ST_CPUPG, ST_PCIREL, ST_RUN
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic pressPulse;
    logic sleepOk;
    logic vrmOk;
    logic stepDone;
    logic toDone;
    logic holdDone;
  } status_t;

  typedef struct packed {
    logic swOnReqN;
    logic suspRailEn;
    logic mainRailEn;
    logic coreVrEnN;
    logic nbPwrOk;
    logic sbPwrOk;
    logic cpuPwrGood;
    logic pciRstN;
    logic cpuRstN;
  } pwrOut_t;

endpackage

// File: rtl/pseq_dp.sv
module pseq_dp #(
  parameter int DEB_CYC    = 16,
  parameter int STEP_CYC   = 64,
  parameter int PG_TIMEOUT = 4096,
  parameter int HOLD_CYC   = 50000,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              buttonN,
  input  logic              sbSlpB,
  input  logic              sbSlpC,
  input  logic              vrmGood,
  input  pseq_pkg::strobe_t strb,
  output pseq_pkg::status_t stat
);
  localparam int NUM_IN = 4;
  localparam int DEB_W  = $clog2(DEB_CYC + 1);
  localparam logic [NUM_IN-1:0] SYNC_INIT = 4'b0001;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncd;
  assign rawIn = {vrmGood, sbSlpC, sbSlpB, buttonN};

  // two-stage synchronisers, one per asynchronous input
  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    logic s1, s2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1 <= SYNC_INIT[i];
        s2 <= SYNC_INIT[i];
      end else begin
        s1 <= rawIn[i];
        s2 <= s1;
      end
    end
    assign syncd[i] = s2;
  end

  // button filter: a new level must persist DEB_CYC samples
  logic             btnStable;
  logic [DEB_W-1:0] debCnt;
  logic             btnDiff, debHit;
  assign btnDiff = syncd[0] ^ btnStable;
  assign debHit  = btnDiff && (debCnt == DEB_W'(DEB_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnStable <= 1'b1;
      debCnt    <= '0;
    end else if (btnDiff) begin
      if (debHit) begin
        btnStable <= syncd[0];
        debCnt    <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end else begin
      debCnt <= '0;
    end
  end

  // shared step/timeout/hold counter
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_comb begin
    stat.pressPulse = debHit && !syncd[0];
    stat.sleepOk    = syncd[1] && syncd[2];
    stat.vrmOk      = syncd[3];
    stat.stepDone   = (cnt == CNT_W'(STEP_CYC - 1));
    stat.toDone     = (cnt == CNT_W'(PG_TIMEOUT - 1));
    stat.holdDone   = (cnt == CNT_W'(HOLD_CYC - 1));
  end

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  pseq_pkg::status_t stat,
  output pseq_pkg::strobe_t strb,
  output pseq_pkg::pwrOut_t pwrOut
);
  import pseq_pkg::*;

  seqState_t state, nextState;
  logic      fault;

  function automatic pwrOut_t decode(seqState_t s);
    pwrOut_t o;
    o.swOnReqN   = (s != ST_REQ);
    o.suspRailEn = (s >= ST_SUSP);
    o.mainRailEn = (s >= ST_MAIN);
    o.coreVrEnN  = !(s >= ST_CORE);
    o.nbPwrOk    = (s >= ST_PWROK);
    o.sbPwrOk    = (s >= ST_PWROK);
    o.cpuPwrGood = (s >= ST_CPUPG);
    o.pciRstN    = (s >= ST_PCIREL);
    o.cpuRstN    = (s == ST_RUN);
    return o;
  endfunction

  assign fault = !stat.sleepOk || !stat.vrmOk;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (stat.pressPulse) nextState = ST_REQ;
      ST_REQ:    if (stat.sleepOk)    nextState = ST_SUSP;
      ST_SUSP:   if (!stat.sleepOk)   nextState = ST_IDLE;
                 else if (stat.stepDone) nextState = ST_MAIN;
      ST_MAIN:   if (!stat.sleepOk)   nextState = ST_IDLE;
                 else if (stat.stepDone) nextState = ST_CORE;
      ST_CORE:   if (!stat.sleepOk)   nextState = ST_IDLE;
                 else if (stat.vrmOk) nextState = ST_PWROK;
                 else if (stat.toDone) nextState = ST_IDLE;
      ST_PWROK:  if (fault)           nextState = ST_IDLE;
                 else if (stat.stepDone) nextState = ST_CPUPG;
      ST_CPUPG:  if (fault)           nextState = ST_IDLE;
                 else if (stat.stepDone) nextState = ST_PCIREL;
      ST_PCIREL: if (fault)           nextState = ST_IDLE;
                 else if (stat.holdDone) nextState = ST_RUN;
      ST_RUN:    if (fault)           nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign strb.cntClr = (nextState != state);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pwrOut <= decode(ST_IDLE);
    end else begin
      state  <= nextState;
      pwrOut <= decode(nextState);
    end
  end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int DEB_CYC    = 16,
  parameter int STEP_CYC   = 64,
  parameter int PG_TIMEOUT = 4096,
  parameter int HOLD_CYC   = 50000
) (
  input  logic clk,
  input  logic rstN,
  input  logic buttonN,
  input  logic sbSlpB,
  input  logic sbSlpC,
  input  logic vrmGood,
  output logic swOnReqN,
  output logic suspRailEn,
  output logic mainRailEn,
  output logic coreVrEnN,
  output logic nbPwrOk,
  output logic sbPwrOk,
  output logic cpuPwrGood,
  output logic pciRstN,
  output logic cpuRstN
);
  localparam int MAX_A = (STEP_CYC > PG_TIMEOUT) ? STEP_CYC : PG_TIMEOUT;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  pseq_pkg::strobe_t strb;
  pseq_pkg::status_t stat;
  pseq_pkg::pwrOut_t pwrOut;

  pseq_dp #(
    .DEB_CYC(DEB_CYC), .STEP_CYC(STEP_CYC), .PG_TIMEOUT(PG_TIMEOUT),
    .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .sbSlpB(sbSlpB),
    .sbSlpC(sbSlpC), .vrmGood(vrmGood), .strb(strb), .stat(stat)
  );

  pseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .stat(stat), .strb(strb), .pwrOut(pwrOut)
  );

  assign swOnReqN   = pwrOut.swOnReqN;
  assign suspRailEn = pwrOut.suspRailEn;
  assign mainRailEn = pwrOut.mainRailEn;
  assign coreVrEnN  = pwrOut.coreVrEnN;
  assign nbPwrOk    = pwrOut.nbPwrOk;
  assign sbPwrOk    = pwrOut.sbPwrOk;
  assign cpuPwrGood = pwrOut.cpuPwrGood;
  assign pciRstN    = pwrOut.pciRstN;
  assign cpuRstN    = pwrOut.cpuRstN;

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
  parameter int PG_TIMEOUT = 4096,
  parameter int HOLD_CYC   = 50000
) (
  input logic clk,
  input logic rstN,
  input logic vrmGood,
  input logic swOnReqN,
  input logic suspRailEn,
  input logic mainRailEn,
  input logic coreVrEnN,
  input logic nbPwrOk,
  input logic sbPwrOk,
  input logic cpuPwrGood,
  input logic pciRstN,
  input logic cpuRstN
);
  int coreWaitCnt;
  int pgHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreWaitCnt <= 0;
      pgHighCnt   <= 0;
    end else begin
      coreWaitCnt <= (!coreVrEnN && !nbPwrOk) ? coreWaitCnt + 1 : 0;
      if (!cpuPwrGood)           pgHighCnt <= 0;
      else if (pgHighCnt < HOLD_CYC) pgHighCnt <= pgHighCnt + 1;
    end
  end

  // R3
  susp_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspRailEn) |-> $past(!swOnReqN));

  // R5
  pwrok_from_vrm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nbPwrOk) |-> ($past(vrmGood, 3) && sbPwrOk));

  // R6
  core_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreWaitCnt <= PG_TIMEOUT);

  // R8
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRstN) |-> (pgHighCnt >= HOLD_CYC));

  // R10
  rail_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainRailEn |-> suspRailEn) and (!coreVrEnN |-> mainRailEn));

  // R10
  pwrok_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nbPwrOk |-> !coreVrEnN) and (cpuPwrGood |-> nbPwrOk));

  // R10
  reset_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pciRstN |-> cpuPwrGood) and (cpuRstN |-> pciRstN));

endmodule

bind pwr_seq_top pseq_chk #(.PG_TIMEOUT(PG_TIMEOUT), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk(clk), .rstN(rstN), .vrmGood(vrmGood), .swOnReqN(swOnReqN),
  .suspRailEn(suspRailEn), .mainRailEn(mainRailEn), .coreVrEnN(coreVrEnN),
  .nbPwrOk(nbPwrOk), .sbPwrOk(sbPwrOk), .cpuPwrGood(cpuPwrGood),
  .pciRstN(pciRstN), .cpuRstN(cpuRstN)
);

// File: tb/pwr_seq_top_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_top_tb_top;
  localparam int DEB  = 4;
  localparam int STEP = 5;
  localparam int PGTO = 20;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonN = 1'b1, sbSlpB = 1'b0, sbSlpC = 1'b0, vrmGood = 1'b0;
  logic swOnReqN, suspRailEn, mainRailEn, coreVrEnN, nbPwrOk, sbPwrOk;
  logic cpuPwrGood, pciRstN, cpuRstN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_seq_top #(.DEB_CYC(DEB), .STEP_CYC(STEP), .PG_TIMEOUT(PGTO), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .sbSlpB(sbSlpB), .sbSlpC(sbSlpC),
    .vrmGood(vrmGood), .swOnReqN(swOnReqN), .suspRailEn(suspRailEn),
    .mainRailEn(mainRailEn), .coreVrEnN(coreVrEnN), .nbPwrOk(nbPwrOk),
    .sbPwrOk(sbPwrOk), .cpuPwrGood(cpuPwrGood), .pciRstN(pciRstN), .cpuRstN(cpuRstN)
  );

  // phase 0 off, 1 request, 2 suspend, 3 main, 4 core, 5 power-OK,
  // 6 CPU power-good, 7 PCI reset released, 8 CPU reset released
  function automatic logic [8:0] expOut(int ph);
    logic [8:0] v;
    v[8] = (ph != 1);
    v[7] = (ph >= 2);
    v[6] = (ph >= 3);
    v[5] = !(ph >= 4);
    v[4] = (ph >= 5);
    v[3] = (ph >= 5);
    v[2] = (ph >= 6);
    v[1] = (ph >= 7);
    v[0] = (ph >= 8);
    return v;
  endfunction

  function automatic logic [8:0] obs();
    return {swOnReqN, suspRailEn, mainRailEn, coreVrEnN, nbPwrOk, sbPwrOk,
            cpuPwrGood, pciRstN, cpuRstN};
  endfunction

  task automatic check(string tag, int ph);
    checks++;
    if (obs() !== expOut(ph)) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, obs(), expOut(ph));
    end
  endtask

  // n falling edges: the old phase until the last, the new one on it
  task automatic holdThen(int n, int fromPh, int toPh, string tag);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      check(tag, fromPh);
    end
    @(negedge clk);
    check(tag, toPh);
  endtask

  task automatic stay(int n, int ph, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, ph);
    end
  endtask

  task automatic cleanup();
    vrmGood = 1'b0; sbSlpB = 1'b0; sbSlpC = 1'b0; buttonN = 1'b1;
    stay(DEB + 4, 0, "R9_idle");
  endtask

  task automatic scenario(int mode);
    int bounce;
    int d;
    // R2: short bounce is ignored
    bounce = $urandom_range(1, DEB - 1);
    @(negedge clk); buttonN = 1'b0;
    stay(bounce - 1, 0, "R2_bounce");
    @(negedge clk); buttonN = 1'b1;
    stay(DEB + 4, 0, "R2_bounce");
    // R2: full press
    buttonN = 1'b0;
    holdThen(DEB + 2, 0, 1, "R2_press");
    buttonN = 1'b1;
    // R3: handshake on both sleep lines
    stay($urandom_range(0, 4), 1, "R3_wait");
    if (mode % 2 == 0) sbSlpB = 1'b1; else sbSlpC = 1'b1;
    stay($urandom_range(3, 6), 1, "R3_wait");
    sbSlpB = 1'b1; sbSlpC = 1'b1;
    holdThen(3, 1, 2, "R3");
    holdThen(STEP, 2, 3, "R4");
    if (mode == 4) begin
      sbSlpB = 1'b0;
      holdThen(3, 3, 0, "R9_sleep");
      cleanup();
      return;
    end
    holdThen(STEP, 3, 4, "R4");
    if (mode == 2) begin
      holdThen(PGTO, 4, 0, "R6_timeout");
      cleanup();
      return;
    end
    if (mode == 3) begin
      stay(PGTO - 2, 4, "R6_late");
      vrmGood = 1'b1;
      holdThen(2, 4, 0, "R6_late");
      cleanup();
      return;
    end
    d = (mode == 1) ? PGTO - 3 : $urandom_range(0, PGTO - 3);
    stay(d, 4, "R5_wait");
    vrmGood = 1'b1;
    holdThen(3, 4, 5, "R5");
    holdThen(STEP, 5, 6, "R7");
    holdThen(STEP, 6, 7, "R7");
    holdThen(HOLD, 7, 8, "R8");
    if (mode == 5) begin
      buttonN = 1'b0;
      stay(DEB + 4, 8, "R2_busy");
      buttonN = 1'b1;
      stay(DEB + 4, 8, "R2_busy");
    end
    if (mode == 1) begin
      sbSlpC = 1'b0;
      holdThen(3, 8, 0, "R9_sleep");
    end else begin
      vrmGood = 1'b0;
      holdThen(3, 8, 0, "R9_vrm");
    end
    cleanup();
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1
    repeat (3) begin
      @(negedge clk);
      check("R1_inreset", 0);
    end
    rstN = 1'b1;
    stay(4, 0, "R1");
    for (int m = 0; m < 6; m++) scenario(m);
    for (int k = 0; k < 8; k++) scenario(int'($urandom_range(0, 5)));
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule